// File: doc/BRIEF.md
# System Address Decoder with Retained Data Bus

This block sits between the CPU of a small 8-bit computer with a 64K address space and every device on the board. On each CPU access it works out which device answers: main memory, the bank ROM window at the top of the map (or a plug-in card that takes that window over), a shared expansion ROM, a per-slot ROM page, a per-slot I/O register, or one of the board's own soft switches. For the soft switches it produces single-cycle strobes and holds the video and annunciator mode bits.

A data bus that nobody drives keeps the last value it carried. The block models this with a bus latch. The latch is updated at the end of each access with whatever the responding device puts on the bus. Bits that are not driven keep their old value. Status reads replace only the top bit. A write leaves the write data on the bus. The CPU reads its result from the latch output in the cycle after the access.

Top module: `sysbus_decode`

## Requirements
- R1: With `acc_en` high, `ram_sel` is set for addresses below 0xC000 (with `ram_we` = `cpu_we`), and `bank_sel` is set for 0xD000–0xFFFF (with `bank_we` = `cpu_we`). On reads only, `exp_rom_sel` is set for 0xC800–0xCFFF, and `slot_rom_sel[n]` is set for 0xCn00–0xCnFF with n in 1..7. No select or strobe is set while `acc_en` is low.
- R2: For 0xC080–0xC0FF, in either direction, `slot_io_sel` is one-hot at index address[6:4], `slot_io_reg` = address[3:0], and `slot_io_we` = `cpu_we`.
- R3: A RAM read loads the latch per bit. A bit where `ram_bit_en` is 1 takes `ram_rdata`. A bit where it is 0 keeps its previous value.
- R4: A bank-window read loads `card_bank_rdata` when `card_inhibit` is 1, and `bank_rom_rdata` otherwise. An expansion ROM, slot ROM or slot I/O read loads that device's data when its drive flag is 1, and leaves the latch unchanged when the flag is 0.
- R5: A read of 0xC000–0xC00F loads `kbd_rdata`. Any access, read or write, to 0xC010–0xC01F pulses `kbd_clr_stb`.
- R6: A read of 0xC020–0xC02F pulses `cass_out_tgl`. A read of 0xC030–0xC03F pulses `spkr_tgl`, and also pulses `cass_out_tgl` when `rev0` is 1.
- R7: An access in either direction to 0xC050–0xC057 pulses `vid_stb` and sets `vid_mode[address[2:1]]` to address[0]. A read of 0xC058–0xC05F sets `ann_state[address[2:1]]` to address[0]. Writes there change nothing.
- R8: A read of 0xC060–0xC06F replaces only bit 7 of the latch. Bit 7 comes from the low 3 address bits: value 0 selects `cass_in`, values 1–3 select `pbtn[v-1]`, and values 4–7 select the inverse of `pdl_timeout[v-4]`.
- R9: A read of 0xC070–0xC07F pulses `pdl_start_stb` and sets latch bit 7 to 1. Bits 6..0 are kept.
- R10: Every write loads the latch with `cpu_wdata`. Switch writes outside 0xC01x and 0xC050–0xC057 pulse no strobe and change no mode bit.
- R11: Reads of 0xC010–0xC05F leave the latch unchanged.
- R12: Reset clears the latch, `vid_mode` and `ann_state`. With `acc_en` low, the latch and the mode bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | A CPU access occupies this cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | CPU write data |
| rev0 | input | 1 | Early board revision: speaker reads also toggle cassette out |
| ram_rdata | input | 8 | RAM read data |
| ram_bit_en | input | 8 | Per-bit RAM drive (1 = chip fitted) |
| slot_rom_rdata | input | 8 | Slot ROM read data |
| slot_rom_drv | input | 1 | Slot ROM drives the bus |
| exp_rom_rdata | input | 8 | Expansion ROM read data |
| exp_rom_drv | input | 1 | Expansion ROM drives the bus |
| bank_rom_rdata | input | 8 | On-board bank ROM data |
| card_bank_rdata | input | 8 | Card data for the bank window |
| card_inhibit | input | 1 | Card takes over the bank window |
| slot_io_rdata | input | 8 | Slot I/O read data |
| slot_io_drv | input | 1 | Slot I/O drives the bus |
| kbd_rdata | input | 8 | Keyboard data byte |
| cass_in | input | 1 | Cassette input level |
| pbtn | input | 3 | Pushbuttons 0–2 |
| pdl_timeout | input | 4 | Paddle timer expired flags 0–3 |
| bus_data | output | 8 | Retained bus latch, CPU read data |
| ram_sel | output | 1 | RAM selected |
| ram_we | output | 1 | RAM write |
| bank_sel | output | 1 | Bank window selected |
| bank_we | output | 1 | Bank window write |
| slot_rom_sel | output | 8 | One-hot slot ROM select (bit 0 unused) |
| exp_rom_sel | output | 1 | Expansion ROM read select |
| slot_io_sel | output | 8 | One-hot slot I/O select |
| slot_io_reg | output | 4 | Slot I/O register number |
| slot_io_we | output | 1 | Slot I/O write |
| kbd_clr_stb | output | 1 | Clear keyboard strobe |
| cass_out_tgl | output | 1 | Toggle cassette output |
| spkr_tgl | output | 1 | Toggle speaker |
| pdl_start_stb | output | 1 | Start all paddle timers |
| vid_stb | output | 1 | Video mode switch accessed |
| vid_mode | output | 4 | Video mode bits |
| ann_state | output | 4 | Annunciator outputs |

## Verification
The bench builds the block with its default 8-bit data width and the fixed 3-bit slot field, which keeps the whole switch page small enough to sweep. All 256 offsets of 0xC0xx are read, and then written, under both values of `rev0`, each one after a write that primes the latch to a known value. A second sweep covers one address in each of the 256 pages with rotating per-bit RAM masks, drive flags and card inhibit. Together the sweeps reach every region, every status source and every retained-bit case.

// File: rtl/sysbus_pkg.sv
// Shared constants and types for the system address decoder.
// Assumes the fixed 16-bit address map of the board; field widths that the
// address layout dictates are collected here so submodules agree on them.
package sysbus_pkg;
    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned SLOT_W  = 3;
    localparam int unsigned NSLOT   = 1 << SLOT_W;
    localparam int unsigned IOREG_W = 4;
    localparam int unsigned N_BTN   = 3;
    localparam int unsigned N_PDL   = 4;
    localparam int unsigned MODE_W  = 2;
    localparam int unsigned N_MODE  = 1 << MODE_W;

    typedef enum logic [2:0] {
        RG_RAM     = 3'd0,
        RG_BANK    = 3'd1,
        RG_EXPROM  = 3'd2,
        RG_SLOTROM = 3'd3,
        RG_SLOTIO  = 3'd4,
        RG_SWITCH  = 3'd5
    } region_t;

    // Group code = address[6:4] inside the motherboard switch page.
    typedef enum logic [2:0] {
        G_KBD    = 3'd0,
        G_KCLR   = 3'd1,
        G_COUT   = 3'd2,
        G_SPKR   = 3'd3,
        G_UTIL   = 3'd4,
        G_VIDANN = 3'd5,
        G_STAT   = 3'd6,
        G_PDL    = 3'd7
    } swgrp_t;
endpackage

// File: rtl/sysbus_region.sv
// Region decoder: classifies a CPU address into one device region.
// Purely combinational; assumes the address is stable for the access cycle.
module sysbus_region
    import sysbus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_t           region
);
    // Priority walk from the top of the map down to the switch page.
    always_comb begin
        if (addr[15:14] != 2'b11)
            region = RG_RAM;
        else if (addr[13:12] != 2'b00)
            region = RG_BANK;
        else if (addr[11])
            region = RG_EXPROM;
        else if (addr[10:8] != '0)
            region = RG_SLOTROM;
        else if (addr[7])
            region = RG_SLOTIO;
        else
            region = RG_SWITCH;
    end
endmodule

// File: rtl/sysbus_switch.sv
// Motherboard soft-switch decoder.
// Turns accesses to the low half of the switch page into single-cycle strobes,
// keeps the video and annunciator mode bits, and picks the status bit that a
// status read places on D7. Assumes 'act' is high only for switch-page accesses.
module sysbus_switch
    import sysbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              we,
    input  logic [6:0]        low,
    input  logic              rev0,
    input  logic              cass_in,
    input  logic [N_BTN-1:0]  pbtn,
    input  logic [N_PDL-1:0]  pdl_timeout,
    output logic              kbd_load,
    output logic              stat_load,
    output logic              stat_bit,
    output logic              kbd_clr_stb,
    output logic              cass_out_tgl,
    output logic              spkr_tgl,
    output logic              pdl_start_stb,
    output logic              vid_stb,
    output logic [N_MODE-1:0] vid_mode,
    output logic [N_MODE-1:0] ann_state
);
    swgrp_t              grp;
    logic                rd;
    logic                ann_hit;
    logic [N_BTN:0]      low_src;

    // Group and direction of the current switch access.
    always_comb begin
        grp = swgrp_t'(low[6:4]);
        rd  = act && !we;
    end

    // Strobes: most act on reads only; keyboard clear and video on both.
    always_comb begin
        kbd_load      = rd  && (grp == G_KBD);
        kbd_clr_stb   = act && (grp == G_KCLR);
        spkr_tgl      = rd  && (grp == G_SPKR);
        cass_out_tgl  = rd  && ((grp == G_COUT) || ((grp == G_SPKR) && rev0));
        pdl_start_stb = rd  && (grp == G_PDL);
        vid_stb       = act && (grp == G_VIDANN) && !low[3];
        ann_hit       = rd  && (grp == G_VIDANN) &&  low[3];
        stat_load     = rd  && ((grp == G_STAT) || (grp == G_PDL));
    end

    // Status source: cassette and buttons low, paddles high, forced 1 for timer start.
    always_comb begin
        low_src = {pbtn, cass_in};
        if (grp == G_PDL)
            stat_bit = 1'b1;
        else if (low[2])
            stat_bit = ~pdl_timeout[low[1:0]];
        else
            stat_bit = low_src[low[1:0]];
    end

    // Mode bits: pair index from address[2:1], value from address[0].
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_mode  <= '0;
            ann_state <= '0;
        end else begin
            if (vid_stb)
                vid_mode[low[2:1]] <= low[0];
            if (ann_hit)
                ann_state[low[2:1]] <= low[0];
        end
    end
endmodule

// File: rtl/sysbus_latch.sv
// Retained data-bus latch.
// Holds the last value on the CPU data bus and merges the responding device's
// data into it at the end of each access. Undriven bits keep their value.
// Assumes the region code and the switch-decoder flags belong to the same cycle.
module sysbus_latch
    import sysbus_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  region_t       region,
    input  logic          kbd_load,
    input  logic          stat_load,
    input  logic          stat_bit,
    input  logic [DW-1:0] ram_rdata,
    input  logic [DW-1:0] ram_bit_en,
    input  logic [DW-1:0] slot_rom_rdata,
    input  logic          slot_rom_drv,
    input  logic [DW-1:0] exp_rom_rdata,
    input  logic          exp_rom_drv,
    input  logic [DW-1:0] bank_rom_rdata,
    input  logic [DW-1:0] card_bank_rdata,
    input  logic          card_inhibit,
    input  logic [DW-1:0] slot_io_rdata,
    input  logic          slot_io_drv,
    input  logic [DW-1:0] kbd_rdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] nxt;

    // Next bus value for the access in progress.
    always_comb begin
        nxt = q;
        if (we) begin
            nxt = wdata;
        end else begin
            unique case (region)
                RG_RAM:     nxt = (ram_rdata & ram_bit_en) | (q & ~ram_bit_en);
                RG_BANK:    nxt = card_inhibit ? card_bank_rdata : bank_rom_rdata;
                RG_EXPROM:  nxt = exp_rom_drv  ? exp_rom_rdata   : q;
                RG_SLOTROM: nxt = slot_rom_drv ? slot_rom_rdata  : q;
                RG_SLOTIO:  nxt = slot_io_drv  ? slot_io_rdata   : q;
                RG_SWITCH: begin
                    if (kbd_load)
                        nxt = kbd_rdata;
                    else if (stat_load)
                        nxt = {stat_bit, q[DW-2:0]};
                end
                default:    nxt = q;
            endcase
        end
    end

    // Latch update on the edge that completes an access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (acc_en)
            q <= nxt;
    end
endmodule

// File: rtl/sysbus_decode.sv
// System address decoder, top level.
// Selects the device for each CPU access, drives device selects and switch
// strobes in the access cycle, and presents the retained bus latch as read data
// from the cycle after. Assumes one access per cycle when acc_en is high.
module sysbus_decode
    import sysbus_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_we,
    input  logic [DW-1:0]       cpu_wdata,
    input  logic                rev0,
    input  logic [DW-1:0]       ram_rdata,
    input  logic [DW-1:0]       ram_bit_en,
    input  logic [DW-1:0]       slot_rom_rdata,
    input  logic                slot_rom_drv,
    input  logic [DW-1:0]       exp_rom_rdata,
    input  logic                exp_rom_drv,
    input  logic [DW-1:0]       bank_rom_rdata,
    input  logic [DW-1:0]       card_bank_rdata,
    input  logic                card_inhibit,
    input  logic [DW-1:0]       slot_io_rdata,
    input  logic                slot_io_drv,
    input  logic [DW-1:0]       kbd_rdata,
    input  logic                cass_in,
    input  logic [N_BTN-1:0]    pbtn,
    input  logic [N_PDL-1:0]    pdl_timeout,
    output logic [DW-1:0]       bus_data,
    output logic                ram_sel,
    output logic                ram_we,
    output logic                bank_sel,
    output logic                bank_we,
    output logic [NSLOT-1:0]    slot_rom_sel,
    output logic                exp_rom_sel,
    output logic [NSLOT-1:0]    slot_io_sel,
    output logic [IOREG_W-1:0]  slot_io_reg,
    output logic                slot_io_we,
    output logic                kbd_clr_stb,
    output logic                cass_out_tgl,
    output logic                spkr_tgl,
    output logic                pdl_start_stb,
    output logic                vid_stb,
    output logic [N_MODE-1:0]   vid_mode,
    output logic [N_MODE-1:0]   ann_state
);
    region_t region;
    logic    rd_act;
    logic    sw_act;
    logic    kbd_load;
    logic    stat_load;
    logic    stat_bit;

    sysbus_region u_region (
        .addr   (cpu_addr),
        .region (region)
    );

    // Access qualifiers shared by the select logic.
    always_comb begin
        rd_act = acc_en && !cpu_we;
        sw_act = acc_en && (region == RG_SWITCH);
    end

    // Memory and ROM window selects.
    always_comb begin
        ram_sel     = acc_en && (region == RG_RAM);
        ram_we      = ram_sel && cpu_we;
        bank_sel    = acc_en && (region == RG_BANK);
        bank_we     = bank_sel && cpu_we;
        exp_rom_sel = rd_act && (region == RG_EXPROM);
        slot_io_reg = cpu_addr[IOREG_W-1:0];
        slot_io_we  = acc_en && (region == RG_SLOTIO) && cpu_we;
    end

    // One-hot per-slot selects for ROM pages and I/O registers.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_rom_sel[s] = rd_act && (region == RG_SLOTROM)
                                 && (cpu_addr[10:8] == SLOT_W'(s));
        assign slot_io_sel[s]  = acc_en && (region == RG_SLOTIO)
                                 && (cpu_addr[6:4] == SLOT_W'(s));
    end

    sysbus_switch u_switch (
        .clk           (clk),
        .rst_n         (rst_n),
        .act           (sw_act),
        .we            (cpu_we),
        .low           (cpu_addr[6:0]),
        .rev0          (rev0),
        .cass_in       (cass_in),
        .pbtn          (pbtn),
        .pdl_timeout   (pdl_timeout),
        .kbd_load      (kbd_load),
        .stat_load     (stat_load),
        .stat_bit      (stat_bit),
        .kbd_clr_stb   (kbd_clr_stb),
        .cass_out_tgl  (cass_out_tgl),
        .spkr_tgl      (spkr_tgl),
        .pdl_start_stb (pdl_start_stb),
        .vid_stb       (vid_stb),
        .vid_mode      (vid_mode),
        .ann_state     (ann_state)
    );

    sysbus_latch #(.DW(DW)) u_latch (
        .clk             (clk),
        .rst_n           (rst_n),
        .acc_en          (acc_en),
        .we              (cpu_we),
        .wdata           (cpu_wdata),
        .region          (region),
        .kbd_load        (kbd_load),
        .stat_load       (stat_load),
        .stat_bit        (stat_bit),
        .ram_rdata       (ram_rdata),
        .ram_bit_en      (ram_bit_en),
        .slot_rom_rdata  (slot_rom_rdata),
        .slot_rom_drv    (slot_rom_drv),
        .exp_rom_rdata   (exp_rom_rdata),
        .exp_rom_drv     (exp_rom_drv),
        .bank_rom_rdata  (bank_rom_rdata),
        .card_bank_rdata (card_bank_rdata),
        .card_inhibit    (card_inhibit),
        .slot_io_rdata   (slot_io_rdata),
        .slot_io_drv     (slot_io_drv),
        .kbd_rdata       (kbd_rdata),
        .q               (bus_data)
    );
endmodule

// File: rtl/sysbus_decode_chk.sv
// Assertion checker for sysbus_decode, attached by bind below.
// Observes ports only; assumes synchronous active-low reset.
module sysbus_decode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        cpu_we,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic [7:0]  bus_data,
    input logic        ram_sel,
    input logic        bank_sel,
    input logic        exp_rom_sel,
    input logic [7:0]  slot_rom_sel,
    input logic [7:0]  slot_io_sel,
    input logic        spkr_tgl,
    input logic        cass_out_tgl,
    input logic        pdl_start_stb,
    input logic [3:0]  ann_state
);
    AST_ONE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ram_sel, bank_sel, exp_rom_sel, |slot_rom_sel, |slot_io_sel}) <= 1); // R1
    AST_IO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_io_sel)); // R2
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && cpu_we) |=> (bus_data == $past(cpu_wdata))); // R10
    AST_WRITE_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && cpu_we) |-> !(spkr_tgl || cass_out_tgl || pdl_start_stb)); // R10
    AST_ANN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && cpu_we) |=> $stable(ann_state)); // R7
    AST_STATUS_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !cpu_we && cpu_addr[15:5] == 11'h603) |=> (bus_data[6:0] == $past(bus_data[6:0]))); // R8
    AST_TIMER_D7_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !cpu_we && cpu_addr[15:4] == 12'hC07) |=> bus_data[7]); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(bus_data)); // R12
endmodule

bind sysbus_decode sysbus_decode_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_en        (acc_en),
    .cpu_we        (cpu_we),
    .cpu_addr      (cpu_addr),
    .cpu_wdata     (cpu_wdata),
    .bus_data      (bus_data),
    .ram_sel       (ram_sel),
    .bank_sel      (bank_sel),
    .exp_rom_sel   (exp_rom_sel),
    .slot_rom_sel  (slot_rom_sel),
    .slot_io_sel   (slot_io_sel),
    .spkr_tgl      (spkr_tgl),
    .cass_out_tgl  (cass_out_tgl),
    .pdl_start_stb (pdl_start_stb),
    .ann_state     (ann_state)
);

// File: tb/sysbus_decode_tb.sv
`timescale 1ns/1ps
module sysbus_decode_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, acc_en, cpu_we, rev0;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata, ram_rdata, ram_bit_en, slot_rom_rdata, exp_rom_rdata;
    logic [7:0]  bank_rom_rdata, card_bank_rdata, slot_io_rdata, kbd_rdata;
    logic        slot_rom_drv, exp_rom_drv, card_inhibit, slot_io_drv, cass_in;
    logic [2:0]  pbtn;
    logic [3:0]  pdl_timeout;
    logic [7:0]  bus_data, slot_rom_sel, slot_io_sel;
    logic        ram_sel, ram_we, bank_sel, bank_we, exp_rom_sel, slot_io_we;
    logic [3:0]  slot_io_reg, vid_mode, ann_state;
    logic        kbd_clr_stb, cass_out_tgl, spkr_tgl, pdl_start_stb, vid_stb;

    sysbus_decode u_dut (.*);

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] m_bus;
    logic [3:0] m_vid, m_ann;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_acc(input logic [15:0] a, input logic we, input logic [7:0] wd);
        logic sw, sio, srom, erom, ram, bank, sb;
        logic [2:0] g;
        logic [7:0] nb, e_srom, e_sio;
        string tg;
        sw   = (a[15:8] == 8'hC0) && !a[7];
        sio  = (a[15:7] == 9'h181);
        srom = (a[15:11] == 5'b11000) && (a[10:8] != 3'd0);
        erom = (a[15:11] == 5'b11001);
        ram  = (a < 16'hC000);
        bank = (a >= 16'hD000);
        g    = a[6:4];
        e_srom = (srom && !we) ? (8'h01 << a[10:8]) : 8'h00;
        e_sio  = sio ? (8'h01 << a[6:4]) : 8'h00;
        @(negedge clk);
        acc_en = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
        #1;
        chk(ram_sel == ram, "R1 ram_sel", ram_sel, ram);
        chk(ram_we == (ram && we), "R1 ram_we", ram_we, ram && we);
        chk(bank_sel == bank, "R1 bank_sel", bank_sel, bank);
        chk(bank_we == (bank && we), "R1 bank_we", bank_we, bank && we);
        chk(exp_rom_sel == (erom && !we), "R1 exp_rom_sel", exp_rom_sel, erom && !we);
        chk(slot_rom_sel == e_srom, "R1 slot_rom_sel", slot_rom_sel, e_srom);
        chk(slot_io_sel == e_sio, "R2 slot_io_sel", slot_io_sel, e_sio);
        if (sio) begin
            chk(slot_io_reg == a[3:0], "R2 slot_io_reg", slot_io_reg, a[3:0]);
            chk(slot_io_we == we, "R2 slot_io_we", slot_io_we, we);
        end else begin
            chk(!slot_io_we, "R2 slot_io_we idle", slot_io_we, 0);
        end
        chk(kbd_clr_stb == (sw && g == 3'd1), "R5 kbd_clr_stb", kbd_clr_stb, sw && g == 3'd1);
        chk(cass_out_tgl == (sw && !we && (g == 3'd2 || (g == 3'd3 && rev0))),
            "R6 cass_out_tgl", cass_out_tgl, sw && !we && (g == 3'd2 || (g == 3'd3 && rev0)));
        chk(spkr_tgl == (sw && !we && g == 3'd3), "R6 spkr_tgl", spkr_tgl, sw && !we && g == 3'd3);
        chk(pdl_start_stb == (sw && !we && g == 3'd7), "R9 pdl_start_stb", pdl_start_stb, sw && !we && g == 3'd7);
        chk(vid_stb == (sw && g == 3'd5 && !a[3]), "R7 vid_stb", vid_stb, sw && g == 3'd5 && !a[3]);
        nb = m_bus;
        tg = "R11 latch kept";
        if (we) begin
            nb = wd; tg = "R10 write data";
        end else if (ram) begin
            nb = (ram_rdata & ram_bit_en) | (m_bus & ~ram_bit_en); tg = "R3 ram merge";
        end else if (bank) begin
            nb = card_inhibit ? card_bank_rdata : bank_rom_rdata; tg = "R4 bank window";
        end else if (erom) begin
            nb = exp_rom_drv ? exp_rom_rdata : m_bus; tg = "R4 exp rom";
        end else if (srom) begin
            nb = slot_rom_drv ? slot_rom_rdata : m_bus; tg = "R4 slot rom";
        end else if (sio) begin
            nb = slot_io_drv ? slot_io_rdata : m_bus; tg = "R4 slot io";
        end else if (g == 3'd0) begin
            nb = kbd_rdata; tg = "R5 keyboard data";
        end else if (g == 3'd6) begin
            if (a[2:0] == 3'd0)   sb = cass_in;
            else if (!a[2])       sb = pbtn[a[1:0] - 2'd1];
            else                  sb = !pdl_timeout[a[1:0]];
            nb = {sb, m_bus[6:0]}; tg = "R8 status bit";
        end else if (g == 3'd7) begin
            nb = {1'b1, m_bus[6:0]}; tg = "R9 timer start D7";
        end
        if (sw && g == 3'd5) begin
            if (!a[3])      m_vid[a[2:1]] = a[0];
            else if (!we)   m_ann[a[2:1]] = a[0];
        end
        @(negedge clk);
        acc_en = 1'b0;
        m_bus = nb;
        chk(bus_data == m_bus, tg, bus_data, m_bus);
        chk(vid_mode == m_vid, "R7 vid_mode", vid_mode, m_vid);
        chk(ann_state == m_ann, "R7 ann_state", ann_state, m_ann);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R12 watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_en = 1'b0; cpu_we = 1'b0; cpu_addr = 16'h0; cpu_wdata = 8'h0;
        rev0 = 1'b0; ram_rdata = 8'h0; ram_bit_en = 8'hFF; slot_rom_rdata = 8'h0;
        exp_rom_rdata = 8'h0; bank_rom_rdata = 8'h0; card_bank_rdata = 8'h0;
        slot_io_rdata = 8'h0; kbd_rdata = 8'h0; slot_rom_drv = 1'b0; exp_rom_drv = 1'b0;
        card_inhibit = 1'b0; slot_io_drv = 1'b0; cass_in = 1'b0; pbtn = 3'h0; pdl_timeout = 4'h0;
        m_bus = 8'h00; m_vid = 4'h0; m_ann = 4'h0;
        repeat (3) @(negedge clk);
        chk(bus_data == 8'h00, "R12 reset latch", bus_data, 0);
        chk(vid_mode == 4'h0, "R12 reset vid_mode", vid_mode, 0);
        chk(ann_state == 4'h0, "R12 reset ann_state", ann_state, 0);
        rst_n = 1'b1;

        // Sweep the whole switch page: prime, read, then write each offset.
        for (int rv = 0; rv < 2; rv++) begin
            rev0 = rv[0];
            for (int off = 0; off < 256; off++) begin
                kbd_rdata = 8'(off) ^ 8'hA5;
                cass_in = off[0]; pbtn = 3'(off >> 1) ^ 3'b101;
                pdl_timeout = 4'(off >> 2) ^ 4'hA;
                slot_io_rdata = 8'(off * 3 + 1); slot_io_drv = off[1];
                do_acc(16'hC040, 1'b1, 8'(off * 29 + rv * 101 + 17));
                do_acc(16'hC000 + 16'(off), 1'b0, 8'h00);
                do_acc(16'hC000 + 16'(off), 1'b1, ~8'(off));
            end
        end

        // One address in every page, with rotating masks and drive flags.
        for (int pass = 0; pass < 2; pass++) begin
            for (int hi = 0; hi < 256; hi++) begin
                ram_rdata = 8'(hi * 7 + 3);
                case (hi % 4)
                    0: ram_bit_en = 8'hFF;
                    1: ram_bit_en = 8'h00;
                    2: ram_bit_en = 8'hF0;
                    default: ram_bit_en = 8'h5A;
                endcase
                slot_rom_rdata = ~8'(hi); slot_rom_drv = hi[0];
                exp_rom_rdata = 8'(hi) ^ 8'h3F; exp_rom_drv = hi[1];
                bank_rom_rdata = 8'(hi) ^ 8'h66; card_bank_rdata = 8'(hi) ^ 8'h99;
                card_inhibit = hi[2]; slot_io_drv = hi[3];
                do_acc(16'hC040, 1'b1, 8'(hi * 13 + pass * 7 + 1));
                do_acc({8'(hi), 8'(hi) ^ (pass == 0 ? 8'h3C : 8'hC3)}, 1'b0, 8'h00);
                do_acc({8'(hi), 8'(hi) ^ 8'h81}, 1'b1, 8'(hi) ^ 8'h24);
            end
        end

        // Idle cycles: inputs move, nothing may respond (R12).
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            cpu_addr = 16'hC030 + 16'(k << 4); cpu_we = k[0]; kbd_rdata = 8'(k);
            #1;
            chk(!(kbd_clr_stb || cass_out_tgl || spkr_tgl || pdl_start_stb || vid_stb || ram_sel
                  || bank_sel || exp_rom_sel || (|slot_rom_sel) || (|slot_io_sel)),
                "R12 idle no strobe", 1, 0);
            @(negedge clk);
            chk(bus_data == m_bus, "R12 idle latch hold", bus_data, m_bus);
            chk(vid_mode == m_vid && ann_state == m_ann, "R12 idle modes hold", vid_mode, m_vid);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule